// File: doc/BRIEF.md
# Eight-Bit Pulse Accumulator with Flag-Based Interrupts

This peripheral keeps an 8-bit accumulator that software reaches over a simple byte-wide register bus. Its job depends on a mode input. In event mode the accumulator advances by one on every edge of the selected polarity seen on an external pin. In gated mode it advances once for every 64 system clocks during which the pin is held at its active level. The pin passes through a two-flop synchronizer before it is used in either mode.

Three registers sit on the bus: the accumulator itself, an interrupt enable register and a status register. Two status bits are live. One marks an accumulator wrap and the other marks an input event. Software clears each one by writing a one to it. Each status bit has an enable bit, and the enabled bits are combined into one interrupt request. The accumulator has no reset, so its value survives a reset pulse. Bit positions that belong to unrelated timer functions are kept so that software can read them back, or they read as zero.

Top module: `pulse_acc_top`

## Requirements
- R1: Address 0 is the accumulator. A bus write stores the byte, and a later read at address 0 returns it. Address 3 reads 0x00.
- R2: Reset leaves the accumulator unchanged. A value written before a reset pulse reads back unchanged after it.
- R3: In event mode (`gated_mode`=0) the accumulator advances by exactly one for each synchronized edge of the selected polarity. `edge_pol`=1 selects rising edges and `edge_pol`=0 selects falling edges. Edges of the other polarity are not counted.
- R4: In event mode every counted edge sets the input flag, which is bit 4 of the status register at address 2.
- R5: In gated mode the accumulator advances once for each 64 consecutive clocks with the pin at its active level. The active level is high when `edge_pol`=1 and low when `edge_pol`=0. The accumulator does not advance while the pin is inactive.
- R6: In gated mode the input flag (bit 4) sets when the gate ends, on the change from active to inactive level, and not while the gate is still open.
- R7: The wrap flag, bit 5 of the status register, sets when the accumulator advances from 0xFF to 0x00. This applies in both modes.
- R8: Writing 1 to bit 5 or bit 4 of the status register clears that flag. Writing 0 leaves it set. Status bits 7, 6 and 3 to 0 always read 0.
- R9: The enable register sits at address 1. Bit 5 enables the wrap interrupt and bit 4 enables the input interrupt. Bits 7, 6, 1 and 0 are stored and read back. Bits 3 and 2 read 0. After reset the enable register and the status register both read 0x00.
- R10: `irq` is high exactly when (bit 5 flag AND bit 5 enable) OR (bit 4 flag AND bit 4 enable) is true. A cleared enable masks the request but leaves the flag set.
- R11: When a bus write to the accumulator and a counting event fall in the same clock, the written value is stored and the event is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset (the accumulator is excluded) |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address: 0 accumulator, 1 enable, 2 status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the register at bus_addr |
| pa_pin | input | 1 | External event or gate pin (asynchronous) |
| edge_pol | input | 1 | 1 = rising edges or active high, 0 = falling edges or active low |
| gated_mode | input | 1 | 0 = event counting, 1 = gated time accumulation |
| irq | output | 1 | Interrupt request |

## Verification
Event counting is driven with pulse trains under both polarities. With the same train, rising and falling selection give different totals, so a polarity swap or a double count shows up. Gated mode uses long high gates, a long idle stretch and an active-low gate. These tell the divide ratio apart from free-running counting, and they separate a flag set on the trailing edge from one set on the leading edge. Preloads of 0xFE in both modes cross the wrap point. A bus write placed in the exact clock of a synchronized edge shows whether the write or the increment takes priority.

// File: rtl/pa_pkg.sv
package pa_pkg;
   localparam int unsigned REG_W = 8;
   localparam logic [1:0] ADDR_CNT  = 2'd0;
   localparam logic [1:0] ADDR_MASK = 2'd1;
   localparam logic [1:0] ADDR_FLAG = 2'd2;
   localparam int unsigned BIT_WRAP = 5;
   localparam int unsigned BIT_IN   = 4;
   // enable-register bits that hold storage; 3 and 2 are fixed at zero
   localparam logic [REG_W-1:0] MASK_KEEP = 8'hF3;
endpackage

// File: rtl/pa_sync.sv
module pa_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("pa_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_async};
   end

   assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/pa_edge.sv
module pa_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   input  logic pol,
   output logic active,
   output logic lead,
   output logic trail
);
   logic lvl_d;
   logic act_d;

   always_ff @(posedge clk) begin
      if (!rst_n) lvl_d <= 1'b0;
      else        lvl_d <= lvl;
   end

   // polarity is applied after the register, so a polarity change alone
   // never looks like an edge
   assign active = pol ? lvl : ~lvl;
   assign act_d  = pol ? lvl_d : ~lvl_d;
   assign lead   = active & ~act_d;
   assign trail  = ~active & act_d;
endmodule

// File: rtl/pa_gate_div.sv
module pa_gate_div #(
   parameter int unsigned DIV = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int unsigned W = (DIV < 2) ? 1 : $clog2(DIV);
   localparam logic [W-1:0] LAST = W'(DIV - 1);

   logic [W-1:0] div_q;

   generate
      if (DIV < 2) begin : g_bad
         $error("pa_gate_div: DIV must be at least 2");
         assign tick = run;
         always_ff @(posedge clk) div_q <= '0;
      end else if ((DIV & (DIV - 1)) == 0) begin : g_pow2
         // power of two: natural wrap of the counter marks the period
         assign tick = run & (&div_q);
         always_ff @(posedge clk) begin
            if (!rst_n || !run) div_q <= '0;
            else                div_q <= div_q + 1'b1;
         end
      end else begin : g_cmp
         assign tick = run & (div_q == LAST);
         always_ff @(posedge clk) begin
            if (!rst_n || !run || tick) div_q <= '0;
            else                        div_q <= div_q + 1'b1;
         end
      end
   endgenerate

   assert_tick_needs_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> run);
endmodule

// File: rtl/pa_counter.sv
module pa_counter #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   input  logic         inc,
   output logic [W-1:0] cnt,
   output logic         wrap
);
   generate
      if (W < 2) begin : g_bad
         $error("pa_counter: W must be at least 2");
      end
   endgenerate

   logic [W-1:0] cnt_q;

   // no reset term: the accumulator keeps its contents across reset
   always_ff @(posedge clk) begin
      if (wr)       cnt_q <= wdata;
      else if (inc) cnt_q <= cnt_q + 1'b1;
   end

   assign cnt  = cnt_q;
   assign wrap = inc & ~wr & (&cnt_q);

   assert_write_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr) |-> cnt_q == $past(wdata));

   assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(wr) && cnt_q != $past(cnt_q)) |-> cnt_q == $past(cnt_q) + W'(1));
endmodule

// File: rtl/pa_regs.sv
module pa_regs
   import pa_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel,
   input  logic             wr,
   input  logic [1:0]       addr,
   input  logic [REG_W-1:0] wdata,
   input  logic [REG_W-1:0] cnt,
   input  logic             in_evt,
   input  logic             wrap_evt,
   output logic             cnt_wr,
   output logic [REG_W-1:0] rdata,
   output logic             irq
);
   logic [REG_W-1:0] mask_q;
   logic             wrap_q;
   logic             in_q;
   logic             mask_wr;
   logic             flag_wr;
   logic [REG_W-1:0] flag_view;

   assign cnt_wr  = sel & wr & (addr == ADDR_CNT);
   assign mask_wr = sel & wr & (addr == ADDR_MASK);
   assign flag_wr = sel & wr & (addr == ADDR_FLAG);

   always_ff @(posedge clk) begin
      if (!rst_n)       mask_q <= '0;
      else if (mask_wr) mask_q <= wdata & MASK_KEEP;
   end

   // a new event outranks a simultaneous clear
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wrap_q <= 1'b0;
         in_q   <= 1'b0;
      end else begin
         if (wrap_evt)                        wrap_q <= 1'b1;
         else if (flag_wr && wdata[BIT_WRAP]) wrap_q <= 1'b0;
         if (in_evt)                          in_q   <= 1'b1;
         else if (flag_wr && wdata[BIT_IN])   in_q   <= 1'b0;
      end
   end

   always_comb begin
      flag_view = '0;
      flag_view[BIT_WRAP] = wrap_q;
      flag_view[BIT_IN]   = in_q;
   end

   always_comb begin
      case (addr)
         ADDR_CNT:  rdata = cnt;
         ADDR_MASK: rdata = mask_q;
         ADDR_FLAG: rdata = flag_view;
         default:   rdata = '0;
      endcase
   end

   assign irq = (wrap_q & mask_q[BIT_WRAP]) | (in_q & mask_q[BIT_IN]);

   assert_wrap_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wrap_q) |-> $past(wrap_evt));

   assert_w1c_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wrap_q) |-> $past(flag_wr && wdata[BIT_WRAP]));

   assert_w0_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(in_q) && !$past(flag_wr && wdata[BIT_IN])) |-> in_q);

   assert_irq_needs_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (wrap_q || in_q));
endmodule

// File: rtl/pulse_acc_top.sv
module pulse_acc_top #(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned GATE_DIV    = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [1:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              pa_pin,
   input  logic              edge_pol,
   input  logic              gated_mode,
   output logic              irq
);
   generate
      if (DATA_W != pa_pkg::REG_W) begin : g_bad
         $error("pulse_acc_top: DATA_W must equal the register width");
      end
   endgenerate

   logic              pin_s;
   logic              gate_on;
   logic              lead;
   logic              trail;
   logic              tick;
   logic              inc;
   logic              in_evt;
   logic              wrap;
   logic              cnt_wr;
   logic [DATA_W-1:0] cnt;

   pa_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_async(pa_pin), .q_sync(pin_s)
   );

   pa_edge u_edge (
      .clk(clk), .rst_n(rst_n), .lvl(pin_s), .pol(edge_pol),
      .active(gate_on), .lead(lead), .trail(trail)
   );

   pa_gate_div #(.DIV(GATE_DIV)) u_div (
      .clk(clk), .rst_n(rst_n), .run(gated_mode & gate_on), .tick(tick)
   );

   assign inc    = gated_mode ? tick : lead;
   assign in_evt = gated_mode ? trail : lead;

   pa_counter #(.W(DATA_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .wr(cnt_wr), .wdata(bus_wdata),
      .inc(inc), .cnt(cnt), .wrap(wrap)
   );

   pa_regs u_regs (
      .clk(clk), .rst_n(rst_n), .sel(bus_sel), .wr(bus_wr),
      .addr(bus_addr), .wdata(bus_wdata), .cnt(cnt),
      .in_evt(in_evt), .wrap_evt(wrap), .cnt_wr(cnt_wr),
      .rdata(bus_rdata), .irq(irq)
   );

   assert_gate_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(gated_mode && !gate_on && !cnt_wr) |-> $stable(cnt));
endmodule

// File: tb/sim_pulse_acc_top.sv
module sim_pulse_acc_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0;
   logic       bus_wr = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       pa_pin = 1'b0;
   logic       edge_pol = 1'b1;
   logic       gated_mode = 1'b0;
   logic       irq;

   int n_vec = 0;
   int n_bad = 0;

   typedef struct {
      logic [7:0] exp;
      string      tag;
   } item_t;
   item_t sb_q[$];
   event  rd_ev;

   always #5 clk = ~clk;

   pulse_acc_top u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pa_pin(pa_pin), .edge_pol(edge_pol), .gated_mode(gated_mode), .irq(irq)
   );

   // monitor: pops the expected read value and compares
   always begin
      @(rd_ev);
      if (sb_q.size() != 0) begin
         item_t it;
         it = sb_q.pop_front();
         n_vec++;
         if (bus_rdata !== it.exp) begin
            n_bad++;
            $display("FAIL %s: read 0x%02h expected 0x%02h", it.tag, bus_rdata, it.exp);
         end
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
      item_t it;
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      it.exp = e; it.tag = tag;
      sb_q.push_back(it);
      #3;
      -> rd_ev;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic chk_irq(input logic e, input string tag);
      @(negedge clk);
      n_vec++;
      if (irq !== e) begin
         n_bad++;
         $display("FAIL %s: irq %0b expected %0b", tag, irq, e);
      end
   endtask

   task automatic pulses(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); pa_pin = 1'b1; idle(4);
         pa_pin = 1'b0; idle(4);
      end
   endtask

   task automatic finish_run;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin
      #1_000_000;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      finish_run();
   end

   initial begin
      idle(4);
      rst_n = 1'b1;
      // R9: reset values
      rd(2'd1, 8'h00, "R9 enable reset");
      rd(2'd2, 8'h00, "R9 status reset");
      chk_irq(1'b0, "R10 irq after reset");
      // R1: accumulator store and readback, unused address
      wr(2'd0, 8'h5A);
      rd(2'd0, 8'h5A, "R1 accumulator readback");
      rd(2'd3, 8'h00, "R1 unused address");
      // R9: enable storage
      wr(2'd1, 8'hFF);
      rd(2'd1, 8'hF3, "R9 enable stored bits");
      // R2: accumulator survives reset; enable does not
      @(negedge clk); rst_n = 1'b0; idle(3); rst_n = 1'b1;
      rd(2'd0, 8'h5A, "R2 accumulator kept");
      rd(2'd1, 8'h00, "R9 enable cleared by reset");

      // R3/R4: rising edge counting
      wr(2'd0, 8'h10);
      pulses(3);
      rd(2'd0, 8'h13, "R3 rising edges");
      rd(2'd2, 8'h10, "R4 input flag");
      wr(2'd2, 8'h00);
      rd(2'd2, 8'h10, "R8 write zero keeps flag");
      wr(2'd2, 8'h10);
      rd(2'd2, 8'h00, "R8 write one clears flag");

      // R3: falling edge counting
      edge_pol = 1'b0;
      wr(2'd0, 8'h00);
      pulses(2);
      rd(2'd0, 8'h02, "R3 falling edges");
      edge_pol = 1'b1;
      wr(2'd2, 8'hFF);

      // R7/R10: wrap in event mode
      wr(2'd0, 8'hFE);
      pulses(2);
      rd(2'd0, 8'h00, "R7 wrap value");
      rd(2'd2, 8'h30, "R7 wrap and input flags");
      chk_irq(1'b0, "R10 masked");
      wr(2'd1, 8'h20);
      chk_irq(1'b1, "R10 wrap enabled");
      wr(2'd2, 8'h20);
      rd(2'd2, 8'h10, "R8 clear wrap only");
      chk_irq(1'b0, "R10 wrap cleared");
      wr(2'd1, 8'h10);
      chk_irq(1'b1, "R10 input enabled");
      wr(2'd2, 8'h30);
      wr(2'd1, 8'h00);

      // R11: write and edge in the same clock
      @(negedge clk); pa_pin = 1'b1;
      @(negedge clk);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 8'h40;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
      idle(3);
      rd(2'd0, 8'h40, "R11 write wins");
      pa_pin = 1'b0; idle(4);
      wr(2'd2, 8'h30);

      // R5/R6: gated mode, active high
      gated_mode = 1'b1;
      wr(2'd0, 8'h00);
      @(negedge clk); pa_pin = 1'b1;
      idle(200);
      rd(2'd0, 8'h03, "R5 gate 200 clocks");
      rd(2'd2, 8'h00, "R6 no flag while open");
      pa_pin = 1'b0; idle(6);
      rd(2'd2, 8'h10, "R6 flag at gate end");
      idle(300);
      rd(2'd0, 8'h03, "R5 no advance when inactive");
      wr(2'd2, 8'h30);

      // R7: wrap in gated mode
      wr(2'd0, 8'hFE);
      @(negedge clk); pa_pin = 1'b1;
      idle(200);
      pa_pin = 1'b0; idle(6);
      rd(2'd0, 8'h01, "R7 gated wrap value");
      rd(2'd2, 8'h30, "R7 gated wrap flag");

      // R5/R6: gated mode, active low
      @(negedge clk); pa_pin = 1'b1;
      edge_pol = 1'b0;
      idle(4);
      wr(2'd2, 8'h30);
      wr(2'd0, 8'h00);
      @(negedge clk); pa_pin = 1'b0;
      idle(140);
      rd(2'd2, 8'h00, "R6 active-low still open");
      pa_pin = 1'b1; idle(6);
      rd(2'd0, 8'h02, "R5 active-low gate");
      rd(2'd2, 8'h10, "R6 active-low gate end");

      idle(4);
      finish_run();
   end
endmodule